// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Control Logic

This block is the digital front end of an 8-bit voltage-output converter with a parallel host port. A host drives a data byte and active-low select and write strobes. The byte is held in a first-stage input register. A second-stage output register then drives the converter code. Every host strobe is asynchronous to the block's clock, so each one passes through a two-flop synchronizer before any edge is detected.

The second stage can be loaded in two ways, and the choice is made separately for each write. The load strobe level is sampled when the write ends. If the load strobe is low at that moment, the output register follows the new byte at once (automatic mode). If it is high, the output register waits for the next falling edge of the load strobe (synchronous mode), so that several converters can change together.

A clear input forces the output code to zero. After reset the block holds a zero code until the first write has completed. A sleep input drops the output-enable flag and leaves both registers as they are. The code is straight binary: 0x00 is zero output and 0xFF is full scale.

Top module: `pdac_ctrl`

## Requirements
- R1: After reset the code is 0x00, out_en is 1 and update_strobe is 0.
- R2: The input register takes din at the end of a selected window. The window is the span in which sel_n and wstb_n are both low, and it ends when either of them rises. Data that changes after the window closes is not taken. A wstb_n pulse while sel_n is high leaves the input register unchanged, which shows on the code at the next load_n falling edge.
- R3: If load_n is low when a write ends, the code takes the written byte. This happens on the third rising clock edge that counts from the edge that first samples the closing strobe.
- R4: If load_n is high when a write ends (after the first write since reset), the code is unchanged. On the next falling edge of load_n the code takes the input register value, with the same three-edge latency.
- R5: If a write begins while load_n is still low and load_n stays low, the write is handled in automatic mode.
- R6: While zero_n is low, the code is 0x00 and every automatic or load_n update is ignored. Writes still reach the input register, so a load_n falling edge after zero_n is released shows the byte written during the clear.
- R7: The first write after reset updates the code whatever the level of load_n.
- R8: While sleep_n is low, out_en is 0 and both registers keep their values. Writes are still accepted. After release, out_en is 1 and the code shows the last byte that was loaded.
- R9: update_strobe pulses high for one cycle in the same cycle that the code register is loaded, and in the cycle that a clear first takes hold. The code never changes without it, and one load_n pulse gives exactly one strobe.
- R10: The code is straight binary: 0xFF and 0x00 written in automatic mode appear on code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on state) |
| sel_n | input | 1 | Active-low chip select strobe, asynchronous |
| wstb_n | input | 1 | Active-low write strobe, asynchronous |
| load_n | input | 1 | Active-low output-load strobe, asynchronous |
| zero_n | input | 1 | Active-low clear of the output code, asynchronous |
| sleep_n | input | 1 | Active-low power-down request, asynchronous |
| din | input | W | Parallel data byte |
| code | output | W | Code driving the converter |
| out_en | output | 1 | Output-enable flag, low while powered down |
| update_strobe | output | 1 | One-cycle pulse on every output register change |

## Verification
The bench closes a window by raising select before write, then changes the data before write rises. A design that latches on the write edge alone would capture the late byte. It writes with load high and checks that the code holds until a load falling edge, and it also writes with load held low from before the write. A design that samples load at the start of the write, or that needs a load edge, shows a stale code. It keeps clear low across both kinds of update and then recovers the byte written during the clear; a design where clear only fires on its edge would let the updates through. It also checks that the first write after reset passes even with load high, and that sleep leaves the code alone while writes continue.

// File: rtl/pdac_ctrl.sv
module pdac_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         wstb_n,
  input  logic         load_n,
  input  logic         zero_n,
  input  logic         sleep_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] code,
  output logic         out_en,
  output logic         update_strobe
);

  localparam int NS = 5;

  logic [NS-1:0] m1, m2, m3;
  logic [W-1:0]  d1, d2, d3;
  logic [W-1:0]  in_reg, dac_reg;
  logic          por, stb, en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '1;
      m2 <= '1;
      m3 <= '1;
      d1 <= '0;
      d2 <= '0;
      d3 <= '0;
    end else begin
      m1 <= {sleep_n, zero_n, load_n, wstb_n, sel_n};
      m2 <= m1;
      m3 <= m2;
      d1 <= din;
      d2 <= d1;
      d3 <= d2;
    end
  end

  logic sel_now, sel_was, wend, ld_s, ld_fall, clr_s, clr_fall, pd_s;

  assign sel_now  = ~m2[0] & ~m2[1];
  assign sel_was  = ~m3[0] & ~m3[1];
  assign wend     = sel_was & ~sel_now;
  assign ld_s     = m2[2];
  assign ld_fall  = m3[2] & ~m2[2];
  assign clr_s    = m2[3];
  assign clr_fall = m3[3] & ~m2[3];
  assign pd_s     = m2[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg  <= '0;
      dac_reg <= '0;
      por     <= 1'b1;
      stb     <= 1'b0;
      en      <= 1'b1;
    end else begin
      en  <= pd_s;
      stb <= 1'b0;
      if (wend) begin
        in_reg <= d3;
        por    <= 1'b0;
      end
      if (!clr_s) begin
        dac_reg <= '0;
        stb     <= clr_fall;
      end else if (wend && (por || !ld_s)) begin
        dac_reg <= d3;
        stb     <= 1'b1;
      end else if (ld_fall) begin
        dac_reg <= in_reg;
        stb     <= 1'b1;
      end
    end
  end

  assign code          = dac_reg;
  assign out_en        = en;
  assign update_strobe = stb;

endmodule

// File: rtl/pdac_ctrl_chk.sv
module pdac_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wend,
  input logic         ld_s,
  input logic         clr_s,
  input logic         por,
  input logic [W-1:0] d3,
  input logic [W-1:0] in_reg,
  input logic [W-1:0] code,
  input logic         update_strobe
);

  assert_input_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wend |=> $stable(in_reg));

  assert_auto_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wend && !ld_s && clr_s) |=> code == $past(d3));

  assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wend && ld_s && !por && clr_s) |=> $stable(code));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> code == '0);

  assert_first_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wend && por && clr_s) |=> code == $past(d3));

  assert_change_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> update_strobe);

endmodule

bind pdac_ctrl pdac_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wend(wend), .ld_s(ld_s), .clr_s(clr_s),
  .por(por), .d3(d3), .in_reg(in_reg), .code(code),
  .update_strobe(update_strobe)
);

// File: tb/tb_pdac_ctrl.sv
module tb_pdac_ctrl;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, sel_n = 1, wstb_n = 1, load_n = 1, zero_n = 1, sleep_n = 1;
  logic [7:0] din = 0;
  logic [7:0] code;
  logic out_en, update_strobe;

  pdac_ctrl #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .load_n(load_n),
    .zero_n(zero_n), .sleep_n(sleep_n), .din(din), .code(code),
    .out_en(out_en), .update_strobe(update_strobe)
  );

  int total = 0, bad = 0, cycles = 0, stb_cnt = 0;

  typedef struct packed { logic [7:0] c; logic e; logic s; } exp_t;
  exp_t q[$];
  exp_t ex;
  bit valid = 0;

  logic [7:0] m_in, m_code, p_din;
  logic m_por, p_sel, p_wr, p_ld, p_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_code = 0; m_por = 1; p_din = 0;
      p_sel = 1; p_wr = 1; p_ld = 1; p_clr = 1;
      q.delete();
      q.push_back('{c: 8'h00, e: 1'b1, s: 1'b0});
      valid = 0;
    end else begin
      bit ended, fell, stb;
      ended = (!p_sel && !p_wr) && !(!sel_n && !wstb_n);
      fell  = p_ld && !load_n;
      stb   = 0;
      if (!zero_n) begin
        m_code = 0;
        stb = p_clr;
      end else if (ended && (m_por || !load_n)) begin
        m_code = p_din; stb = 1;
      end else if (fell) begin
        m_code = m_in; stb = 1;
      end
      if (ended) begin m_in = p_din; m_por = 0; end
      q.push_back('{c: m_code, e: sleep_n, s: stb});
      p_sel = sel_n; p_wr = wstb_n; p_ld = load_n; p_clr = zero_n; p_din = din;
    end
    if (q.size() > 2) begin ex = q.pop_front(); valid = 1; end
  end

  always @(negedge clk) begin
    cycles++;
    if (update_strobe) stb_cnt++;
    if (valid && rst_n) begin
      total += 3;
      if (code !== ex.c) begin bad++; $display("FAIL R3 model code act=%h exp=%h t=%0t", code, ex.c, $time); end
      if (out_en !== ex.e) begin bad++; $display("FAIL R8 model out_en act=%b exp=%b t=%0t", out_en, ex.e, $time); end
      if (update_strobe !== ex.s) begin bad++; $display("FAIL R9 model strobe act=%b exp=%b t=%0t", update_strobe, ex.s, $time); end
    end
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<=50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic wr_op(input logic [7:0] v, input logic ld);
    load_n = ld; din = v; sel_n = 0; tick(2);
    wstb_n = 0; tick(3);
    wstb_n = 1; tick(2);
    sel_n = 1; tick(6);
  endtask

  task automatic ld_pulse;
    load_n = 0; tick(3);
    load_n = 1; tick(6);
  endtask

  initial begin
    tick(5); rst_n = 1; tick(4);
    chk("R1 code after reset", code, 8'h00);
    chk("R1 out_en after reset", out_en, 1);
    chk("R1 strobe after reset", update_strobe, 0);

    wr_op(8'h5A, 1);
    chk("R7 first write passes", code, 8'h5A);

    wr_op(8'h33, 1);
    chk("R4 sync write holds code", code, 8'h5A);
    stb_cnt = 0;
    ld_pulse();
    chk("R4 load edge updates code", code, 8'h33);
    chk("R9 one strobe per load", stb_cnt, 1);

    wr_op(8'hC4, 0);
    chk("R3 auto write", code, 8'hC4);
    wr_op(8'h81, 0);
    chk("R5 write while load low", code, 8'h81);
    load_n = 1; tick(4);

    din = 8'h3C; sel_n = 0; wstb_n = 0; tick(3);
    sel_n = 1; tick(2); din = 8'hE7; tick(2); wstb_n = 1; tick(4);
    chk("R2 select-first end holds code", code, 8'h81);
    din = 8'h11; wstb_n = 0; tick(3); wstb_n = 1; tick(4);
    ld_pulse();
    chk("R2 captured before select rose", code, 8'h3C);

    stb_cnt = 0;
    zero_n = 0; tick(5);
    chk("R6 clear zeroes code", code, 8'h00);
    chk("R9 strobe on clear", stb_cnt, 1);
    wr_op(8'h77, 0);
    chk("R6 auto ignored in clear", code, 8'h00);
    load_n = 1; tick(3);
    ld_pulse();
    chk("R6 load ignored in clear", code, 8'h00);
    zero_n = 1; tick(5);
    chk("R6 code zero after release", code, 8'h00);
    ld_pulse();
    chk("R6 input reg kept through clear", code, 8'h77);

    sleep_n = 0; tick(5);
    chk("R8 out_en low in sleep", out_en, 0);
    chk("R8 code kept in sleep", code, 8'h77);
    wr_op(8'h99, 0);
    chk("R8 out_en still low", out_en, 0);
    sleep_n = 1; tick(5);
    chk("R8 out_en after wake", out_en, 1);
    chk("R8 sleep write visible", code, 8'h99);

    wr_op(8'hFF, 0);
    chk("R10 full scale", code, 8'hFF);
    wr_op(8'h00, 0);
    chk("R10 zero code", code, 8'h00);
    load_n = 1; tick(3);

    rst_n = 0; tick(4); rst_n = 1; tick(4);
    chk("R1 code after second reset", code, 8'h00);
    wr_op(8'hA5, 1);
    chk("R7 first write after second reset", code, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule